// File: doc/BRIEF.md
# Internal Clock Rate Selector

This block turns one fast internal reference clock and one slow, independent internal clock into a single output clock. The output rate is picked by a 3-bit rate code. Codes 001 to 111 take taps from a free-running binary divider that the fast clock drives. Code 111 gives the undivided fast clock, and each lower code halves the rate. With an 8 MHz reference, code 001 gives 125 kHz. Code 000 does not use the divider. It routes the slow 31 kHz clock straight to the output.

Software-side logic writes the rate code at any time. The written value is held in a programmed register. It takes over the output mux only at the next divider wrap, when every divider tap falls together, so the output never switches in the middle of a divided period. During a write, a combinational flag reports whether the change moves between the two oscillator families, which needs an oscillator start-up, or only moves to another divider tap. Reset programs the 4 MHz code 110.

Top module: `intclk_rate_select`

## Requirements
- R1: After reset, `selCode` and `activeSel` both read 110 (divide by 2), and `needsSourceSwitch` is low while `selWrEn` is low.
- R2: When `selWrEn` is high at a rising `hfClk` edge, `selCode` takes `selWrData` at that edge. With `selWrEn` low, `selCode` keeps its value whatever `selWrData` does.
- R3: The divider is a 6-bit counter. It is cleared by reset and advances once per rising `hfClk` edge. For an active code c from 001 to 110, `clkOut` equals counter bit (6 - c), which is the reference divided by 2^(7-c).
- R4: With active code 111, `clkOut` follows `hfClk` itself.
- R5: With active code 000, `clkOut` follows `lfClk`.
- R6: `activeSel` changes only at the rising `hfClk` edge where the counter goes from all ones to zero. It then takes the code held in `selCode` just before that edge.
- R7: `needsSourceSwitch` is high exactly when `selWrEn` is high and exactly one of `selCode` and `selWrData` equals 000.
- R8: A write captured on the same edge at which the counter wraps is not applied at that edge. It is applied at the next wrap, 64 edges later.
- R9: When several writes land between two wraps, the last written code is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hfClk | input | 1 | Fast reference clock; drives the divider and all registers |
| lfClk | input | 1 | Slow independent clock, routed out for code 000 |
| rstN | input | 1 | Asynchronous active-low reset |
| selWrEn | input | 1 | Write strobe for the rate code |
| selWrData | input | 3 | Rate code to write |
| selCode | output | 3 | Programmed rate code |
| activeSel | output | 3 | Rate code currently steering the output mux |
| needsSourceSwitch | output | 1 | Write crosses between divider and slow-clock families |
| clkOut | output | 1 | Selected output clock |

## Verification
A register write and a divider-wrap commit can fall on the same rising edge. The bench provokes this by waiting until the counter model reads 63 and then placing a write on the next edge. It judges the result by requiring `activeSel` to keep the old code through that edge and to take the new code exactly 64 edges later. Two writes inside one divider period are also issued back to back, and the bench checks that only the second one reaches the mux.

// File: rtl/intclk_sel_pkg.sv
package intclk_sel_pkg;
  localparam int CODE_W     = 3;
  localparam int NUM_TAPS   = 2 ** CODE_W;
  localparam int DIV_STAGES = NUM_TAPS - 2;

  typedef logic [CODE_W-1:0] rateCode_t;

  localparam rateCode_t LF_CODE = '0;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;   // a programmed code is waiting for the next wrap
    logic      useLf;  // waiting code routes the slow clock
    rateCode_t code;   // waiting code
  } rateStrobe_t;
endpackage

// File: rtl/intclk_sel_ctrl.sv
module intclk_sel_ctrl
  import intclk_sel_pkg::*;
#(
  parameter rateCode_t RESET_CODE = 3'b110
) (
  input  logic        hfClk,
  input  logic        rstN,
  input  logic        selWrEn,
  input  rateCode_t   selWrData,
  input  logic        wrapTick,
  output rateCode_t   selCode,
  output logic        needsSourceSwitch,
  output rateStrobe_t strobe
);

  rateCode_t selReg;
  logic      pendingQ;

  always_ff @(posedge hfClk or negedge rstN) begin
    if (!rstN) begin
      selReg   <= RESET_CODE;
      pendingQ <= 1'b0;
    end else begin
      if (selWrEn) begin
        selReg   <= selWrData;
        pendingQ <= 1'b1;
      end else if (wrapTick) begin
        pendingQ <= 1'b0;
      end
    end
  end

  logic curIsLf;
  logic newIsLf;

  always_comb begin
    curIsLf           = (selReg == LF_CODE);
    newIsLf           = (selWrData == LF_CODE);
    needsSourceSwitch = selWrEn && (curIsLf != newIsLf);
    strobe.load       = pendingQ;
    strobe.useLf      = curIsLf;
    strobe.code       = selReg;
  end

  assign selCode = selReg;

endmodule

// File: rtl/intclk_sel_dp.sv
module intclk_sel_dp
  import intclk_sel_pkg::*;
#(
  parameter rateCode_t RESET_CODE = 3'b110
) (
  input  logic        hfClk,
  input  logic        lfClk,
  input  logic        rstN,
  input  rateStrobe_t strobe,
  output logic        wrapTick,
  output rateCode_t   activeSel,
  output logic        clkOut
);

  typedef logic [DIV_STAGES-1:0] divCnt_t;

  divCnt_t   divCnt;
  rateCode_t actCode;
  logic      actLf;

  always_ff @(posedge hfClk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      actCode <= RESET_CODE;
      actLf   <= (RESET_CODE == LF_CODE);
    end else begin
      divCnt <= divCnt + divCnt_t'(1);
      if (wrapTick && strobe.load) begin
        actCode <= strobe.code;
        actLf   <= strobe.useLf;
      end
    end
  end

  assign wrapTick = &divCnt;

  // tap g: 0 = undivided reference, 1..DIV_STAGES = counter bits, rest unused
  logic [NUM_TAPS-1:0] taps;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    if (g == 0) begin : gRef
      assign taps[g] = hfClk;
    end else if (g <= DIV_STAGES) begin : gDiv
      assign taps[g] = divCnt[g-1];
    end else begin : gNone
      assign taps[g] = 1'b0;
    end
  end

  rateCode_t tapSel;

  always_comb begin
    tapSel = ~actCode;  // highest code -> tap 0
    clkOut = actLf ? lfClk : taps[tapSel];
  end

  assign activeSel = actCode;

endmodule

// File: rtl/intclk_rate_select.sv
module intclk_rate_select
  import intclk_sel_pkg::*;
#(
  parameter rateCode_t RESET_CODE = 3'b110
) (
  input  logic                                hfClk,
  input  logic                                lfClk,
  input  logic                                rstN,
  input  logic                                selWrEn,
  input  logic [intclk_sel_pkg::CODE_W-1:0]   selWrData,
  output logic [intclk_sel_pkg::CODE_W-1:0]   selCode,
  output logic [intclk_sel_pkg::CODE_W-1:0]   activeSel,
  output logic                                needsSourceSwitch,
  output logic                                clkOut
);

  rateStrobe_t strobe;
  logic        wrapTick;

  intclk_sel_ctrl #(.RESET_CODE(RESET_CODE)) u_ctrl (
    .hfClk             (hfClk),
    .rstN              (rstN),
    .selWrEn           (selWrEn),
    .selWrData         (selWrData),
    .wrapTick          (wrapTick),
    .selCode           (selCode),
    .needsSourceSwitch (needsSourceSwitch),
    .strobe            (strobe)
  );

  intclk_sel_dp #(.RESET_CODE(RESET_CODE)) u_dp (
    .hfClk     (hfClk),
    .lfClk     (lfClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrapTick  (wrapTick),
    .activeSel (activeSel),
    .clkOut    (clkOut)
  );

endmodule

// File: rtl/intclk_rate_select_chk.sv
module intclk_rate_select_chk
  import intclk_sel_pkg::*;
(
  input logic      hfClk,
  input logic      rstN,
  input logic      selWrEn,
  input rateCode_t selWrData,
  input rateCode_t selCode,
  input rateCode_t activeSel,
  input logic      needsSourceSwitch,
  input logic      wrapTick
);

  assert_wr_capture_R2: assert property (@(posedge hfClk) disable iff (!rstN)
    selWrEn |=> (selCode == $past(selWrData)));

  assert_wr_hold_R2: assert property (@(posedge hfClk) disable iff (!rstN)
    !selWrEn |=> $stable(selCode));

  assert_wrap_single_R3: assert property (@(posedge hfClk) disable iff (!rstN)
    wrapTick |=> !wrapTick);

  assert_commit_edge_R6: assert property (@(posedge hfClk) disable iff (!rstN)
    !$stable(activeSel) |-> $past(wrapTick));

  assert_commit_value_R6: assert property (@(posedge hfClk) disable iff (!rstN)
    !$stable(activeSel) |-> (activeSel == $past(selCode)));

  assert_flag_gate_R7: assert property (@(posedge hfClk) disable iff (!rstN)
    !selWrEn |-> !needsSourceSwitch);

  assert_flag_cross_R7: assert property (@(posedge hfClk) disable iff (!rstN)
    (selWrEn && ((selCode == LF_CODE) != (selWrData == LF_CODE))) |-> needsSourceSwitch);

endmodule

bind intclk_rate_select intclk_rate_select_chk u_chk (
  .hfClk             (hfClk),
  .rstN              (rstN),
  .selWrEn           (selWrEn),
  .selWrData         (selWrData),
  .selCode           (selCode),
  .activeSel         (activeSel),
  .needsSourceSwitch (needsSourceSwitch),
  .wrapTick          (wrapTick)
);

// File: tb/sim_intclk_rate_select.sv
`timescale 1ns/100ps
module sim_intclk_rate_select;

  logic       hfClk = 1'b0;
  logic       lfClk = 1'b0;
  logic       rstN  = 1'b0;
  logic       selWrEn = 1'b0;
  logic [2:0] selWrData = 3'b000;
  logic [2:0] selCode;
  logic [2:0] activeSel;
  logic       needsSourceSwitch;
  logic       clkOut;

  int checks = 0;
  int errors = 0;
  int ticks = 0;
  int writeTick = 0;
  int commitTick = 0;

  always #10 hfClk = ~hfClk;   // 50 MHz
  always #300 lfClk = ~lfClk;  // slow independent clock

  always @(posedge hfClk) if (rstN) ticks = ticks + 1;

  intclk_rate_select u0 (
    .hfClk(hfClk), .lfClk(lfClk), .rstN(rstN),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .selCode(selCode), .activeSel(activeSel),
    .needsSourceSwitch(needsSourceSwitch), .clkOut(clkOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling hfClk edge
  task automatic writeCode(input logic [2:0] c);
    selWrEn = 1'b1;
    selWrData = c;
    @(posedge hfClk); #1;
    writeTick = ticks;
    check(selCode == c, "R2", "selCode after write", selCode, c);
    @(negedge hfClk); #1;
    selWrEn = 1'b0;
  endtask

  task automatic waitCommit(input logic [2:0] oldC, input logic [2:0] newC);
    bit early = 0;
    int seenOld = oldC;
    commitTick = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge hfClk); #1;
      if ((ticks % 64) == 0 && ticks > writeTick) begin
        commitTick = ticks;
        check(activeSel == newC, "R6", "activeSel at wrap", activeSel, newC);
        break;
      end else if (activeSel != oldC) begin
        early = 1;
        seenOld = activeSel;
      end
    end
    check(!early && commitTick >= 0, "R6", "activeSel before wrap", seenOld, oldC);
  endtask

  task automatic checkDivide(input int c);
    bit bad = 0;
    int act = 0, exp = 0;
    for (int i = 0; i < 130; i++) begin
      @(negedge hfClk); #1;
      if (clkOut !== (((ticks % 64) >> (6 - c)) & 1)) begin
        bad = 1; act = clkOut; exp = ((ticks % 64) >> (6 - c)) & 1;
      end
    end
    check(!bad, "R3", $sformatf("divided clock code %0d", c), act, exp);
  endtask

  task automatic flagCheck(input logic en, input logic [2:0] d, input logic exp);
    selWrEn = en;
    selWrData = d;
    #2;
    check(needsSourceSwitch == exp, "R7",
          $sformatf("flag cur=%0d new=%0d en=%0d", selCode, d, en),
          needsSourceSwitch, exp);
    selWrEn = 1'b0;
    @(negedge hfClk); #1;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge hfClk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(selCode == 3'b110, "R1", "selCode after reset", selCode, 6);
    check(activeSel == 3'b110, "R1", "activeSel after reset", activeSel, 6);
    check(needsSourceSwitch == 1'b0, "R1", "flag after reset", needsSourceSwitch, 0);
    checkDivide(6);

    // R7 from a divider code
    flagCheck(1'b1, 3'b000, 1'b1);
    flagCheck(1'b1, 3'b101, 1'b0);
    flagCheck(1'b0, 3'b000, 1'b0);

    // R3 retap to a deeper divider
    writeCode(3'b011);
    waitCommit(3'b110, 3'b011);
    checkDivide(3);

    // R2 no write -> no change
    for (int i = 0; i < 6; i++) begin
      selWrData = 3'(i);
      @(negedge hfClk); #1;
    end
    check(selCode == 3'b011, "R2", "selCode without strobe", selCode, 3);
    check(activeSel == 3'b011, "R2", "activeSel without strobe", activeSel, 3);

    // R4 undivided reference
    writeCode(3'b111);
    waitCommit(3'b011, 3'b111);
    begin
      bool_loop: for (int i = 0; i < 8; i++) begin
        @(posedge hfClk); #5;
        check(clkOut == 1'b1, "R4", "clkOut high phase", clkOut, 1);
        @(negedge hfClk); #1;
        check(clkOut == 1'b0, "R4", "clkOut low phase", clkOut, 0);
      end
    end

    // R5 slow clock
    writeCode(3'b000);
    waitCommit(3'b111, 3'b000);
    begin
      bit bad = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge hfClk); #1;
        if (clkOut !== lfClk) bad = 1;
      end
      check(!bad, "R5", "clkOut follows slow clock", clkOut, lfClk);
    end
    flagCheck(1'b1, 3'b100, 1'b1);
    flagCheck(1'b1, 3'b000, 1'b0);

    // R8 write on the wrap edge
    while ((ticks % 64) != 63) begin @(negedge hfClk); #1; end
    writeCode(3'b001);
    check((writeTick % 64) == 0, "R8", "write landed on wrap edge", writeTick % 64, 0);
    waitCommit(3'b000, 3'b001);
    check(commitTick == writeTick + 64, "R8", "commit tick", commitTick, writeTick + 64);
    checkDivide(1);

    // R9 last write wins
    while ((ticks % 64) != 2) begin @(negedge hfClk); #1; end
    writeCode(3'b010);
    writeCode(3'b101);
    waitCommit(3'b001, 3'b101);
    check(activeSel == 3'b101, "R9", "last write applied", activeSel, 5);
    checkDivide(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule